// File: doc/BRIEF.md
# Lane-Partitioned Saturating Absolute Value Unit

This unit takes one 32-bit instruction word together with a 128-bit source operand and, when the word encodes a signed saturating absolute value operation, produces the destination value and the source and destination register indices. The operand is split into signed lanes of 8, 16, 32 or 64 bits. Each lane becomes its absolute value, and the result is clamped to the positive range of that lane width. Two forms are accepted. The scalar form processes a single element. The vector form processes 64 or 128 bits of data, and the lane count follows from that data width.

The outputs are registered and appear one clock after a valid input. A word that does not encode the operation, or that uses the reserved vector arrangement, raises an undefined-instruction pulse and writes nothing. A sticky saturation flag records any clamp and is cleared only on request. The register file and the privilege-based enable checks are handled elsewhere.

Top module: `sat_abs_unit`

## Requirements
- R1: A scalar word has instr[31:24]=8'h5E, instr[21:10]=12'h81E, size=instr[23:22], source index instr[9:5] and destination index instr[4:0]. It processes one element of width 8<<size taken from operand bit 0 upward. One cycle later the unit drives out_valid=1, rn=instr[9:5] and rd=instr[4:0].
- R2: A vector word has instr[31]=0, Q=instr[30], instr[29:24]=6'h0E, instr[21:10]=12'h81E, and the size and index fields in the same positions as in R1. It processes 64 bits of data when Q=0 and 128 bits when Q=1.
- R3: Each processed lane is a two's-complement integer of width 8<<size and is replaced by its absolute value. Non-negative lanes pass through unchanged.
- R4: A lane that holds the most negative value of its width becomes the largest positive value of that width.
- R5: In the scalar form, every result bit above the element is zero.
- R6: In the vector form with Q=0, result bits 127:64 are zero, whatever the upper operand bits are.
- R7: A vector word with size=11 and Q=0 is reserved. One cycle later the unit pulses undef=1 and keeps out_valid=0. The result, rd, rn and qc keep their previous values.
- R8: A word that matches neither form behaves as described in R7.
- R9: qc becomes 1 one cycle after a legal operation in which any processed lane saturates. It then stays at 1 until it is cleared. A clamp in a lane that is not processed does not set qc.
- R10: qc_clear=1 makes qc 0 on the next cycle. When qc_clear arrives together with a saturating operation, qc ends at 1.
- R11: Outputs are registered one cycle after in_valid. With in_valid=0 the next cycle shows out_valid=0 and undef=0, and the result and indices are held.
- R12: After reset, out_valid, undef and qc are 0, and the result, rd and rn are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operand are present |
| instr | input | 32 | Instruction word |
| operand | input | 128 | Source operand value |
| qc_clear | input | 1 | Clear request for the saturation flag |
| out_valid | output | 1 | Result, rd and rn were updated this cycle |
| result | output | 128 | Destination value |
| rd | output | 5 | Destination register index |
| rn | output | 5 | Source register index |
| undef | output | 1 | Undefined-instruction pulse |
| qc | output | 1 | Sticky cumulative saturation flag |

## Verification
The hardest case to reach from the ports is a clamp in a lane the operation does not process. Reaching it needs a lane at its most negative value above the processed width, in the upper half of a 64-bit vector or above a scalar element, and qc must stay 0 while the visible bits remain correct. The stimulus first clears qc. It then applies operands whose only most-negative lanes sit in those masked regions, and separately applies the reserved 2D arrangement with such lanes. Around these directed cases, randomized legal words are mixed with random clear requests, and every cycle is compared against an independent lane model.

// File: rtl/sat_abs_pkg.sv
// Shared constants and decoded-instruction type for the saturating absolute value unit.
// Assumes a fixed 32-bit instruction word and 5-bit register indices.
package sat_abs_pkg;
    localparam int INSTR_W = 32;
    localparam int REG_IDX_W = 5;
    localparam int SIZE_W = 2;
    localparam logic [7:0]  SCALAR_TOP = 8'h5E;
    localparam logic [5:0]  VECTOR_TOP = 6'h0E;
    localparam logic [11:0] OP_MIDDLE  = 12'h81E;

    typedef struct packed {
        logic                 legal;
        logic                 scalar;
        logic                 q;
        logic [SIZE_W-1:0]    size;
        logic [REG_IDX_W-1:0] rd;
        logic [REG_IDX_W-1:0] rn;
    } dec_t;
endpackage

// File: rtl/sat_abs_decode.sv
// Instruction decoder: recognises the scalar and vector forms, rejects the reserved
// arrangement (size=11, Q=0 in vector form) and extracts the fields.
// Purely combinational; the caller qualifies the output with its valid strobe.
module sat_abs_decode
    import sat_abs_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic mid_ok;
    logic is_scalar;
    logic is_vector;
    logic reserved;

    // Match the fixed opcode fields of each form and flag the reserved arrangement.
    always_comb begin
        mid_ok    = (instr[21:10] == OP_MIDDLE);
        is_scalar = mid_ok && (instr[31:24] == SCALAR_TOP);
        is_vector = mid_ok && !instr[31] && (instr[29:24] == VECTOR_TOP);
        reserved  = is_vector && (instr[23:22] == 2'b11) && !instr[30];
        dec.legal  = (is_scalar || is_vector) && !reserved;
        dec.scalar = is_scalar;
        dec.q      = instr[30];
        dec.size   = instr[23:22];
        dec.rn     = instr[9:5];
        dec.rd     = instr[4:0];
    end
endmodule

// File: rtl/sat_abs_lane.sv
// One lane: signed absolute value clamped to the positive range of LANE_W bits.
// Assumes two's-complement input; sat is high only for the most negative value.
module sat_abs_lane #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout,
    output logic              sat
);
    localparam logic [LANE_W-1:0] MOST_NEG = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [LANE_W-1:0] MOST_POS = {1'b0, {(LANE_W-1){1'b1}}};

    // Negate negative values, clamping the one value whose negation overflows.
    always_comb begin
        sat = (din == MOST_NEG);
        if (sat)
            dout = MOST_POS;
        else if (din[LANE_W-1])
            dout = (~din) + LANE_W'(1);
        else
            dout = din;
    end
endmodule

// File: rtl/sat_abs_bank.sv
// A bank of lanes of one width covering the full operand. Lanes that lie wholly
// below proc_bits are processed; the others output zero and cannot report saturation.
// Assumes DATA_W is a multiple of LANE_W and that proc_bits is a multiple of LANE_W.
module sat_abs_bank #(
    parameter int DATA_W = 128,
    parameter int LANE_W = 8,
    parameter int PB_W   = 8
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [PB_W-1:0]   proc_bits,
    output logic [DATA_W-1:0] result,
    output logic              sat_any
);
    localparam int N_LANES = DATA_W / LANE_W;

    logic [N_LANES-1:0] lane_sat;
    logic [N_LANES-1:0] lane_on;

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        localparam logic [PB_W-1:0] LANE_END = PB_W'((k + 1) * LANE_W);
        logic [LANE_W-1:0] lane_out;

        sat_abs_lane #(.LANE_W(LANE_W)) u_lane (
            .din  (operand[k*LANE_W +: LANE_W]),
            .dout (lane_out),
            .sat  (lane_sat[k])
        );

        // Enable the lane only when it lies inside the processed width.
        always_comb begin
            lane_on[k] = (LANE_END <= proc_bits);
            result[k*LANE_W +: LANE_W] = lane_on[k] ? lane_out : '0;
        end
    end

    // Collect saturation from enabled lanes only.
    always_comb sat_any = |(lane_sat & lane_on);
endmodule

// File: rtl/sat_abs_unit.sv
// Top: decodes the word, runs one lane bank per supported width, selects the bank
// matching the size field and registers result, indices, undef pulse and sticky qc.
// Assumes DATA_W/2 >= the widest lane and that NUM_SIZES matches the 2-bit size field.
module sat_abs_unit
    import sat_abs_pkg::*;
#(
    parameter int DATA_W    = 128,
    parameter int ELEM_MIN  = 8,
    parameter int NUM_SIZES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [DATA_W-1:0]    operand,
    input  logic                 qc_clear,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    result,
    output logic [REG_IDX_W-1:0] rd,
    output logic [REG_IDX_W-1:0] rn,
    output logic                 undef,
    output logic                 qc
);
    localparam int PB_W = $clog2(DATA_W + 1);

    dec_t              dec;
    logic [PB_W-1:0]   proc_bits;
    logic [DATA_W-1:0] bank_res [NUM_SIZES];
    logic [NUM_SIZES-1:0] bank_sat;
    logic [DATA_W-1:0] sel_res;
    logic              sel_sat;
    logic              fire;
    logic              bad;

    sat_abs_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    // Processed data width: one element for scalar, half or full operand for vector.
    always_comb begin
        if (dec.scalar)
            proc_bits = PB_W'(ELEM_MIN) << dec.size;
        else if (dec.q)
            proc_bits = PB_W'(DATA_W);
        else
            proc_bits = PB_W'(DATA_W / 2);
    end

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_bank
        sat_abs_bank #(
            .DATA_W (DATA_W),
            .LANE_W (ELEM_MIN << s),
            .PB_W   (PB_W)
        ) u_bank (
            .operand   (operand),
            .proc_bits (proc_bits),
            .result    (bank_res[s]),
            .sat_any   (bank_sat[s])
        );
    end

    // Pick the bank for the decoded lane width and qualify with the strobe.
    always_comb begin
        sel_res = bank_res[dec.size];
        sel_sat = bank_sat[dec.size];
        fire    = in_valid && dec.legal;
        bad     = in_valid && !dec.legal;
    end

    // Output registers: result and indices update only on a legal operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            undef     <= 1'b0;
            result    <= '0;
            rd        <= '0;
            rn        <= '0;
        end else begin
            out_valid <= fire;
            undef     <= bad;
            if (fire) begin
                result <= sel_res;
                rd     <= dec.rd;
                rn     <= dec.rn;
            end
        end
    end

    // Sticky saturation flag: a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            qc <= 1'b0;
        else
            qc <= (qc && !qc_clear) || (fire && sel_sat);
    end
endmodule

// File: rtl/sat_abs_checker.sv
// Property checker for sat_abs_unit, attached through bind. Observes ports only.
module sat_abs_checker #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       instr,
    input logic              qc_clear,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              undef,
    input logic              qc
);
    logic vec_half_op;
    logic vec_byte_op;
    logic bad_mid;
    logic byte_neg;

    // Port-level classification of the incoming word and of the result lanes.
    always_comb begin
        bad_mid     = in_valid && (instr[21:10] != 12'h81E);
        vec_half_op = in_valid && (instr[21:10] == 12'h81E) && !instr[31]
                      && !instr[30] && (instr[29:24] == 6'h0E) && (instr[23:22] != 2'b11);
        vec_byte_op = in_valid && (instr[21:10] == 12'h81E) && !instr[31]
                      && (instr[29:24] == 6'h0E) && (instr[23:22] == 2'b00);
        byte_neg = 1'b0;
        for (int b = 0; b < DATA_W / 8; b++)
            byte_neg = byte_neg | result[b*8 + 7];
    end

    // R11: a result strobe always follows an input strobe.
    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    // R7: an undefined word never also reports a result.
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && undef));
    // R7: the result is held when undef pulses.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> $stable(result));
    // R8: a word with the wrong middle field is undefined.
    a_r8_undef: assert property (@(posedge clk) disable iff (!rst_n)
        bad_mid |=> undef);
    // R9: the flag stays set without a clear.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (qc && !qc_clear) |=> qc);
    // R10: a clear with no operation empties the flag.
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (qc_clear && !in_valid) |=> !qc);
    // R6: a 64-bit vector leaves the upper half zero.
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        vec_half_op |=> (result[DATA_W-1:DATA_W/2] == '0));
    // R4: byte lanes are never negative after the operation.
    a_r4_no_negative: assert property (@(posedge clk) disable iff (!rst_n)
        vec_byte_op |=> !byte_neg);
endmodule

bind sat_abs_unit sat_abs_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .qc_clear  (qc_clear),
    .out_valid (out_valid),
    .result    (result),
    .undef     (undef),
    .qc        (qc)
);

// File: tb/sat_abs_unit_tb.sv
module sat_abs_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] operand = '0;
    logic         qc_clear = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic [4:0]   rd;
    logic [4:0]   rn;
    logic         undef;
    logic         qc;

    int errors = 0;
    int checks = 0;
    bit started = 0;

    typedef struct {
        logic         vld;
        logic         und;
        logic [127:0] res;
        logic [4:0]   rd;
        logic [4:0]   rn;
        logic         qc;
        string        tag;
    } item_t;

    item_t sb[$];

    logic [127:0] e_res = '0;
    logic [4:0]   e_rd = '0;
    logic [4:0]   e_rn = '0;
    logic         e_qc = 1'b0;

    always #5 clk = ~clk;

    sat_abs_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .operand(operand), .qc_clear(qc_clear), .out_valid(out_valid),
        .result(result), .rd(rd), .rn(rn), .undef(undef), .qc(qc)
    );

    function automatic logic [31:0] w_scalar(logic [1:0] sz, logic [4:0] n, logic [4:0] d);
        return {8'h5E, sz, 12'h81E, n, d};
    endfunction

    function automatic logic [31:0] w_vector(logic q, logic [1:0] sz, logic [4:0] n, logic [4:0] d);
        return {1'b0, q, 6'h0E, sz, 12'h81E, n, d};
    endfunction

    // Lane model from R3/R4: returns {sat, result} for the processed width.
    function automatic logic [128:0] model(logic [127:0] op, int w, int pbits);
        logic [127:0] r = '0;
        logic s_any = 1'b0;
        for (int k = 0; (k + 1) * w <= pbits; k++) begin
            logic [63:0] lane = 64'(op >> (k * w));
            longint sv;
            longint minv;
            longint a;
            sv = longint'(lane << (64 - w)) >>> (64 - w);
            minv = longint'(64'h1 << (w - 1));
            if (sv == -minv) begin
                a = minv - 1;
                s_any = 1'b1;
            end else begin
                a = (sv < 0) ? -sv : sv;
            end
            r = r | (128'(64'(a)) << (k * w));
        end
        return {s_any, r};
    endfunction

    // Driver: applies one cycle of stimulus and pushes the expected outcome.
    task automatic drive(logic v, logic [31:0] iw, logic [127:0] op, logic clr, string tag);
        item_t it;
        logic mid, sc, vc, legal;
        int w, pb;
        logic [128:0] m;
        @(negedge clk);
        in_valid = v; instr = iw; operand = op; qc_clear = clr;
        mid = (iw[21:10] == 12'h81E);
        sc = mid && (iw[31:24] == 8'h5E);
        vc = mid && !iw[31] && (iw[29:24] == 6'h0E) && !(iw[23:22] == 2'b11 && !iw[30]);
        legal = sc || vc;
        w = 8 << iw[23:22];
        pb = sc ? w : (iw[30] ? 128 : 64);
        m = model(op, w, pb);
        it.vld = v && legal;
        it.und = v && !legal;
        if (v && legal) begin
            e_res = m[127:0];
            e_rd = iw[4:0];
            e_rn = iw[9:5];
        end
        e_qc = (e_qc && !clr) || (v && legal && m[128]);
        it.res = e_res; it.rd = e_rd; it.rn = e_rn; it.qc = e_qc; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0, '0, 1'b0, "R11 idle");
    endtask

    // Monitor: compares every cycle after the edge that follows each drive.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (started && sb.size() > 0) begin
                item_t e;
                e = sb.pop_front();
                checks++;
                if (out_valid !== e.vld || undef !== e.und || result !== e.res
                    || rd !== e.rd || rn !== e.rn) begin
                    errors++;
                    $display("FAIL %s: got v=%b u=%b rd=%0d rn=%0d res=%h exp v=%b u=%b rd=%0d rn=%0d res=%h",
                             e.tag, out_valid, undef, rd, rn, result, e.vld, e.und, e.rd, e.rn, e.res);
                end
                checks++;
                if (qc !== e.qc) begin
                    errors++;
                    $display("FAIL %s (qc, R9/R10): got qc=%b exp qc=%b", e.tag, qc, e.qc);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state.
        checks++;
        if (out_valid !== 1'b0 || undef !== 1'b0 || qc !== 1'b0 || result !== '0
            || rd !== '0 || rn !== '0) begin
            errors++;
            $display("FAIL R12: got v=%b u=%b qc=%b res=%h exp all zero", out_valid, undef, qc, result);
        end
        rst_n = 1'b1;
        started = 1;

        // R1 R4 R5: scalar byte most negative, upper garbage.
        drive(1'b1, w_scalar(2'b00, 5'd3, 5'd7), {{120{1'b1}}, 8'h80}, 1'b0, "R1 R4 R5 scalar byte");
        // R10: clear alone.
        drive(1'b0, '0, '0, 1'b1, "R10 clear");
        // R3: 16 bytes mixed.
        drive(1'b1, w_vector(1'b1, 2'b00, 5'd1, 5'd2),
              128'h7F_00_01_FF_80_81_C0_40_05_FB_10_F0_7E_82_00_FF, 1'b0, "R2 R3 R4 vector 16B");
        drive(1'b0, '0, '0, 1'b1, "R10 clear");
        // R3: positive only, no saturation.
        drive(1'b1, w_vector(1'b1, 2'b01, 5'd4, 5'd5),
              128'h0001_7FFF_1234_0000_0FFF_0100_2000_0003, 1'b0, "R3 vector 8H positive");
        drive(1'b1, w_vector(1'b1, 2'b10, 5'd6, 5'd8),
              128'h8000_0000_FFFF_FFFF_7FFF_FFFF_F000_0001, 1'b0, "R3 R4 vector 4S");
        drive(1'b0, '0, '0, 1'b1, "R10 clear");
        drive(1'b1, w_vector(1'b1, 2'b11, 5'd9, 5'd10),
              128'h8000_0000_0000_0000_FFFF_FFFF_FFFF_FFFE, 1'b0, "R3 R4 vector 2D");
        // R10: clear and saturating op together.
        drive(1'b1, w_vector(1'b0, 2'b01, 5'd11, 5'd12),
              128'h1111_2222_3333_4444_8000_FFFF_0002_FF00, 1'b1, "R10 set wins over clear");
        drive(1'b0, '0, '0, 1'b1, "R10 clear");
        // R6 R9: 64-bit vector, clamp-worthy lanes only in the upper half.
        drive(1'b1, w_vector(1'b0, 2'b00, 5'd13, 5'd14),
              128'h80808080_80808080_01FF0203_FE04FD05, 1'b0, "R6 R9 masked upper lanes");
        drive(1'b1, w_vector(1'b0, 2'b10, 5'd15, 5'd16),
              128'h80000000_80000000_FFFFFF00_00000100, 1'b0, "R6 vector 2S");
        // R5 R9: scalar halfword with most negative lanes above element.
        drive(1'b1, w_scalar(2'b01, 5'd17, 5'd18), 128'h8000_8000_8000_8000_8000_8000_8000_FFF0,
              1'b0, "R5 R9 scalar H masked");
        drive(1'b1, w_scalar(2'b11, 5'd19, 5'd20), 128'h8000_0000_0000_0000_8000_0000_0000_0000,
              1'b0, "R1 R4 R5 scalar D");
        drive(1'b0, '0, '0, 1'b1, "R10 clear");
        // R7: reserved 2D with Q=0, lanes that would clamp.
        drive(1'b1, w_vector(1'b0, 2'b11, 5'd21, 5'd22), {2{64'h8000_0000_0000_0000}},
              1'b0, "R7 reserved");
        // R8: unrelated words.
        drive(1'b1, 32'hDEADBEEF, {16{8'h80}}, 1'b0, "R8 no match");
        drive(1'b1, {1'b1, 1'b1, 6'h0E, 2'b00, 12'h81E, 5'd1, 5'd1}, {16{8'h80}}, 1'b0, "R8 bit31 set");
        // R11: word present but strobe low.
        drive(1'b0, w_vector(1'b1, 2'b00, 5'd23, 5'd24), {16{8'h80}}, 1'b0, "R11 no strobe");
        idle(2);
        // Randomized legal and illegal words with random clears.
        for (int i = 0; i < 300; i++) begin
            logic [1:0] sz = 2'($urandom);
            logic qb = 1'($urandom);
            logic [127:0] op = {$urandom, $urandom, $urandom, $urandom};
            logic [31:0] iw;
            if ($urandom % 3 == 0) op = op & {16{8'h80}};
            case ($urandom % 4)
                0: iw = w_scalar(sz, 5'($urandom), 5'($urandom));
                3: iw = $urandom;
                default: iw = w_vector(qb, sz, 5'($urandom), 5'($urandom));
            endcase
            drive(1'($urandom % 4 != 0), iw, op, 1'($urandom % 8 == 0), "R3 R9 random");
        end
        idle(3);
        @(posedge clk);
        #3;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule